// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block derives the serial clock of a two-wire bus controller from the input clock. A programmable prescaler divides the input clock into a slower module-clock enable. Two period counters then time the low and the high halves of SCL in module-clock units. Each half lasts its programmed count plus a fixed pipeline offset. The offset is 7 module clocks when the prescale value is 0, 6 when it is 1, and 5 when it is 2 or more. A build-time option forces the offset to 6 for every prescale value.

The controller holds the generator in a soft reset (`ctl_rst_i`) while it reprograms the prescale, low and high values. The block copies these values only during that reset, and they take effect when the reset is released. While SCL is released high, the high-phase counter waits until the sampled line actually reads high, so a target that stretches the clock lengthens the high phase. Two strobes, each one input clock wide, mark the middle of each phase: one for changing SDA during the low phase and one for sampling SDA during the high phase. A high count of zero keeps SCL released and produces no strobes.

Top module: `scl_timing_gen`

## Requirements
- R1: After `ctl_rst_i` is sampled low, `scl_o` goes low in the next cycle. The low phase lasts (P+1)*(L+d) input clocks, where P is the prescale value, L is the low count and d is the offset.
- R2: The high phase follows the low phase with no idle cycle and lasts (P+1)*(H+d) input clocks when the line is not stretched. The two phases then alternate.
- R3: With the default build, d is 7 for P=0, 6 for P=1 and 5 for P>=2.
- R4: With `FIXED_D`=1, d is 6 for every prescale value.
- R5: If the high count captured during soft reset is 0, `scl_o` stays 1 after release and neither strobe ever pulses.
- R6: `psc_i`, `low_i` and `high_i` are captured only while `ctl_rst_i` is 1. Changing them while running does not alter any phase length.
- R7: While `scl_o` is 1 and `scl_i` reads 0, the high phase does not advance and `sda_smp_o` stays 0. With P=0, `scl_o` falls exactly H+d cycles after the line is first sampled high.
- R8: `sda_chg_o` pulses exactly once per low phase, for one input clock, at (P+1)*floor((L+d)/2) input clocks after the first cycle of the low phase.
- R9: `sda_smp_o` pulses exactly once per unstretched high phase, for one input clock, at (P+1)*floor((H+d)/2) input clocks after the first cycle of the high phase. It pulses only while `scl_i` is 1.
- R10: In the cycle after `ctl_rst_i` is sampled 1, `scl_o` is 1 and both strobes are 0. The next release starts a full-length low phase. `scl_o` is also 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_rst_i | input | 1 | Soft reset: disables the generator and captures the configuration |
| psc_i | input | PSC_W | Prescale value P; module clock = input clock / (P+1) |
| low_i | input | DIV_W | Low count L |
| high_i | input | DIV_W | High count H; 0 stops the generator |
| scl_i | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL request: 1 releases the line, 0 drives it low |
| sda_chg_o | output | 1 | Mid-low strobe for changing SDA |
| sda_smp_o | output | 1 | Mid-high strobe for sampling SDA |

## Verification
The bench builds the default widths (4-bit prescale, 8-bit counts) twice: once with the prescale-dependent offset and once with `FIXED_D`=1. Both instances get the same configuration. Prescale values 0 to 3 reach all three offset branches of the default build and show how the forced offset differs from each. Small counts keep each period to a few dozen cycles, so many phases can be compared exactly. Prescale 0 makes the stretch timing exact to the cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam int unsigned D_W       = 3;
  localparam logic [2:0]  D_PSC0    = 3'd7;
  localparam logic [2:0]  D_PSC1    = 3'd6;
  localparam logic [2:0]  D_PSCN    = 3'd5;
  localparam logic [2:0]  D_FIXED   = 3'd6;
endpackage

// File: rtl/scl_offset_sel.sv
module scl_offset_sel
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W   = 4,
  parameter bit          FIXED_D = 1'b0
) (
  input  logic [PSC_W-1:0] psc_i,
  output logic [D_W-1:0]   d_o
);
  if (FIXED_D) begin : g_fixed
    logic unused_psc;
    assign unused_psc = ^psc_i;
    assign d_o = D_FIXED;
  end else begin : g_scaled
    always_comb begin
      if (psc_i == '0)                d_o = D_PSC0;
      else if (psc_i == PSC_W'(1))    d_o = D_PSC1;
      else                            d_o = D_PSCN;
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o,
  output logic             first_o
);
  logic [PSC_W-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (!run_i)          pcnt_q <= '0;
    else if (pcnt_q == div_i) pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + PSC_W'(1);
  end

  assign tick_o  = run_i && (pcnt_q == div_i);
  assign first_o = run_i && (pcnt_q == '0);
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             first_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  output scl_phase_e       phase_o,
  output logic             mid_low_o,
  output logic             mid_high_o
);
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             advance;

  assign len     = (phase_q == PH_HIGH) ? high_len_i : low_len_i;
  // high phase only counts once the line really reads high
  assign advance = tick_i && ((phase_q == PH_LOW) || line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (advance) begin
      if (cnt_q == len - CNT_W'(1)) begin
        phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase_o    = phase_q;
  assign mid_low_o  = run_i && (phase_q == PH_LOW) && first_i &&
                      (cnt_q == (low_len_i >> 1));
  assign mid_high_o = run_i && (phase_q == PH_HIGH) && first_i && line_i &&
                      (cnt_q == (high_len_i >> 1));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned PSC_W   = 4,
  parameter int unsigned DIV_W   = 8,
  parameter bit          FIXED_D = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_rst_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [DIV_W-1:0] low_i,
  input  logic [DIV_W-1:0] high_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             sda_chg_o,
  output logic             sda_smp_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [PSC_W-1:0] psc_q;
  logic [DIV_W-1:0] low_q, high_q;
  logic             run_q;
  logic [D_W-1:0]   d;
  logic [CNT_W-1:0] low_len, high_len;
  logic             tick, first;
  scl_phase_e       phase;

  // configuration shadow: loads only during soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      low_q  <= '0;
      high_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (ctl_rst_i) begin
        psc_q  <= psc_i;
        low_q  <= low_i;
        high_q <= high_i;
      end
      run_q <= !ctl_rst_i && (high_q != '0);
    end
  end

  scl_offset_sel #(.PSC_W(PSC_W), .FIXED_D(FIXED_D)) i_offset (
    .psc_i (psc_q),
    .d_o   (d)
  );

  assign low_len  = CNT_W'(low_q)  + CNT_W'(d);
  assign high_len = CNT_W'(high_q) + CNT_W'(d);

  scl_prescaler #(.PSC_W(PSC_W)) i_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .div_i   (psc_q),
    .tick_o  (tick),
    .first_o (first)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .tick_i     (tick),
    .first_i    (first),
    .line_i     (scl_i),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .phase_o    (phase),
    .mid_low_o  (sda_chg_o),
    .mid_high_o (sda_smp_o)
  );

  assign scl_o = !run_q || (phase == PH_HIGH);
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctl_rst_i,
  input logic scl_i,
  input logic scl_o,
  input logic sda_chg_o,
  input logic sda_smp_o
);
  AST_CHG_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |-> !scl_o); // R8

  AST_CHG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sda_chg_o && sda_smp_o)); // R8

  AST_SMP_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |-> (scl_o && scl_i)); // R9

  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && !scl_i) |=> scl_o); // R7

  AST_DISABLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_i |=> (scl_o && !sda_chg_o && !sda_smp_o)); // R10
endmodule

bind scl_timing_gen scl_timing_chk i_scl_timing_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctl_rst_i (ctl_rst_i),
  .scl_i     (scl_i),
  .scl_o     (scl_o),
  .sda_chg_o (sda_chg_o),
  .sda_smp_o (sda_smp_o)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_rst = 1'b1;
  logic [3:0] psc = '0;
  logic [7:0] low = '0, high = '0;
  logic       stretch = 1'b0;
  logic       scl, chg, smp, scl2, chg2, smp2, line;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign line = scl & ~stretch;

  scl_timing_gen i_scl_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .ctl_rst_i(ctl_rst), .psc_i(psc),
    .low_i(low), .high_i(high), .scl_i(line), .scl_o(scl),
    .sda_chg_o(chg), .sda_smp_o(smp));

  scl_timing_gen #(.FIXED_D(1'b1)) i_scl_timing_gen_fixd (
    .clk_i(clk), .rst_ni(rst_n), .ctl_rst_i(ctl_rst), .psc_i(psc),
    .low_i(low), .high_i(high), .scl_i(scl2), .scl_o(scl2),
    .sda_chg_o(chg2), .sda_smp_o(smp2));

  typedef struct {
    bit    lvl;
    int    len;
    int    mid;
    string tag;
  } phase_t;
  phase_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: measures each completed phase and pops the expected item
  bit mon_en = 1'b0, ph_valid = 1'b0, prev_lvl = 1'b1;
  int run_len = 0, n_chg = 0, n_smp = 0, off_chg = -1, off_smp = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl != prev_lvl) begin
        if (mon_en && ph_valid && exp_q.size() > 0) begin
          phase_t e;
          e = exp_q.pop_front();
          check(e.lvl == prev_lvl, e.tag, int'(prev_lvl), int'(e.lvl));
          check(run_len == e.len, {e.tag, (e.lvl ? " R2 len" : " R1 len")}, run_len, e.len);
          if (!e.lvl) begin
            check(n_chg == 1 && n_smp == 0, "R8 count", n_chg, 1);
            check(off_chg == e.mid, "R8 offset", off_chg, e.mid);
          end else begin
            check(n_smp == 1 && n_chg == 0, "R9 count", n_smp, 1);
            check(off_smp == e.mid, "R9 offset", off_smp, e.mid);
          end
        end
        ph_valid = mon_en;
        run_len = 0; n_chg = 0; n_smp = 0; off_chg = -1; off_smp = -1;
      end
      if (chg) begin n_chg++; off_chg = run_len; end
      if (smp) begin n_smp++; off_smp = run_len; end
      run_len++;
      prev_lvl = scl;
      if (!mon_en) ph_valid = 1'b0;
    end
  end

  task automatic run_cfg(input int p, input int lo, input int hi, input int nper,
                         input string tag);
    int d, ll, hl, n;
    d  = (p == 0) ? 7 : (p == 1) ? 6 : 5;
    ll = (p + 1) * (lo + d);
    hl = (p + 1) * (hi + d);
    @(negedge clk);
    ctl_rst = 1'b1; psc = 4'(p); low = 8'(lo); high = 8'(hi);
    repeat (3) @(negedge clk);
    for (int i = 0; i < nper; i++) begin
      exp_q.push_back('{1'b0, ll, (p + 1) * ((lo + d) / 2), tag});
      exp_q.push_back('{1'b1, hl, (p + 1) * ((hi + d) / 2), tag});
    end
    mon_en = 1'b1;
    ctl_rst = 1'b0;
    @(negedge clk);
    // R6: new values while running must be ignored
    psc = 4'(p + 5); low = 8'(lo + 9); high = 8'(hi + 17);
    n = 0;
    while (scl2 == 1'b0) begin n++; @(negedge clk); end
    check(n == (p + 1) * (lo + 6), "R4 fixed-offset low", n, (p + 1) * (lo + 6));
    while (exp_q.size() != 0) @(negedge clk);
    mon_en = 1'b0;
    ctl_rst = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl == 1'b1 && !chg && !smp, "R10 reset state", int'(scl), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl == 1'b1, "R10 soft reset idle", int'(scl), 1);

    run_cfg(0, 4, 3, 2, "R3 R6 p0");
    run_cfg(1, 5, 2, 2, "R3 R6 p1");
    run_cfg(3, 6, 3, 2, "R3 R6 p3");
    run_cfg(2, 10, 20, 2, "R3 R6 p2");

    // R5: zero high count
    begin
      int bad;
      @(negedge clk);
      ctl_rst = 1'b1; psc = 4'd0; low = 8'd4; high = 8'd0;
      repeat (3) @(negedge clk);
      ctl_rst = 1'b0;
      bad = 0;
      repeat (100) begin
        @(negedge clk);
        if (!scl || chg || smp) bad++;
      end
      check(bad == 0, "R5 zero high stays released", bad, 0);
      ctl_rst = 1'b1;
    end

    // R10: disable mid low phase, then full restart
    begin
      int n;
      @(negedge clk);
      ctl_rst = 1'b1; psc = 4'd1; low = 8'd5; high = 8'd2;
      repeat (3) @(negedge clk);
      ctl_rst = 1'b0;
      repeat (6) @(negedge clk);
      check(scl == 1'b0, "R1 low before disable", int'(scl), 0);
      ctl_rst = 1'b1;
      @(negedge clk);
      check(scl == 1'b1 && !chg && !smp, "R10 released after disable", int'(scl), 1);
      repeat (2) @(negedge clk);
      ctl_rst = 1'b0;
      @(negedge clk);
      n = 0;
      while (scl == 1'b0) begin n++; @(negedge clk); end
      check(n == 22, "R10 full low after restart", n, 22);
      ctl_rst = 1'b1;
    end

    // R7: clock stretching with prescale 0
    begin
      int n, bad;
      @(negedge clk);
      ctl_rst = 1'b1; psc = 4'd0; low = 8'd4; high = 8'd3;
      repeat (3) @(negedge clk);
      ctl_rst = 1'b0;
      @(negedge clk);
      stretch = 1'b1;
      while (scl == 1'b0) @(negedge clk);
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (!scl || smp) bad++;
      end
      check(bad == 0, "R7 held while stretched", bad, 0);
      stretch = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (scl == 1'b1 && n < 100);
      check(n == 10, "R7 high after stretch", n, 10);
      ctl_rst = 1'b1;
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule